// File: doc/BRIEF.md
# Overlapping 2x2 Tower Cluster Finder

This block takes one full snapshot of a calorimeter trigger tower grid, indexed by eta and phi, and reduces it to a map of cluster candidates. Each tower arrives as an 8-bit electromagnetic energy, an 8-bit hadronic energy and a veto bit. The two energies are added into a 9-bit tower energy, and any tower below a programmable floor is zeroed. A 2x2 window is then summed at every grid position, so that neighbouring windows share towers.

A filter keeps only those windows that are local maxima among the windows that overlap them and that reach a pruning floor. A fixed raster-order tie rule ensures that two equal overlapping windows are never both kept. The grid is loaded in parallel, one snapshot per cycle, and a full map of cluster energies, keep flags and OR-ed vetoes comes out a fixed three cycles later. Downstream isolation, identification and sorting logic consume this map.

Top module: `clus_grid_top`

## Requirements
- R1: Tower t (index t = eta*N_PHI + phi; its electromagnetic energy at bits [8t+7:8t] of `ecal_in`, hadronic at the same bits of `hcal_in`) has energy ecal+hcal as a 9-bit value when that sum is at least `tower_thr`, and energy zero otherwise.
- R2: The cluster at (eta,phi), reported at bits [11i+10:11i] of `clus_e` with i = eta*N_PHI + phi, is the 11-bit sum of towers (eta,phi), (eta+1,phi), (eta,phi+1) and (eta+1,phi+1). Towers outside the grid count as zero.
- R3: `clus_veto[i]` is the OR of the veto bits of the in-grid towers of cluster i, whatever their energy.
- R4: A cluster is a local maximum when its energy is strictly greater than each overlapping in-grid neighbour (eta and phi offsets within ±1) with a lower index. It must also be greater than or equal to each such neighbour with a higher index. Two overlapping clusters are never both kept.
- R5: `clus_keep[i]` is set only for a local maximum whose energy is at least `prune_thr`.
- R6: A cluster of zero energy is never kept, even when `prune_thr` is zero.
- R7: The map for a snapshot presented with `in_valid` high at clock edge k appears with `out_valid` high after edge k+3. Snapshots may follow on consecutive cycles.
- R8: While `rst_n` is low at a clock edge, `out_valid`, `clus_keep`, `clus_veto` and `clus_e` are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Snapshot on the tower inputs is valid |
| ecal_in | input | 8*N_ETA*N_PHI | Electromagnetic energies, tower t at [8t+7:8t] |
| hcal_in | input | 8*N_ETA*N_PHI | Hadronic energies, tower t at [8t+7:8t] |
| veto_in | input | N_ETA*N_PHI | Per-tower veto bits |
| tower_thr | input | 9 | Tower energy floor (static while data flows) |
| prune_thr | input | 11 | Cluster pruning floor (static while data flows) |
| out_valid | output | 1 | Output map is valid |
| clus_e | output | 11*N_ETA*N_PHI | Cluster energies, position i at [11i+10:11i] |
| clus_keep | output | N_ETA*N_PHI | Cluster kept by filter and prune |
| clus_veto | output | N_ETA*N_PHI | OR of the cluster's tower vetoes |

## Verification
Every result of this block is due three rising edges after the snapshot is driven. These are the tower threshold stage, the window summing stage and the filter stage. The bench drives each snapshot on a falling edge and samples energies, keep flags, vetoes and `out_valid` on the third falling edge after it. It checks that `out_valid` drops one cycle later. In the back-to-back test, two snapshots are driven on consecutive falling edges and their maps are sampled on the third and fourth falling edges, so each result is checked in its own slot of the pipeline.

// File: rtl/clus_pkg.sv
// Package: shared widths and the staged tower record for the cluster finder.
// Assumes: energies are unsigned; widths are fixed by the tower format.
package clus_pkg;
    localparam int CAL_W = 8;   // width of one calorimeter energy input
    localparam int TOW_W = 9;   // tower energy width (sum of two CAL_W values)
    localparam int CLU_W = 11;  // cluster width (sum of four TOW_W values)

    typedef struct packed {
        logic             veto;
        logic [TOW_W-1:0] e;
    } tower_t;
endpackage

// File: rtl/clus_tower_front.sv
// Module: clus_tower_front
// Adds the two calorimeter energies of each tower and zeroes towers below
// the floor. The result is registered as pipeline stage 1. The veto passes
// through untouched.
// Assumes: tower_thr is held steady while snapshots flow.
module clus_tower_front #(
    parameter int N_ETA = 8,
    parameter int N_PHI = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N_ETA*N_PHI*clus_pkg::CAL_W-1:0]  ecal_in,
    input  logic [N_ETA*N_PHI*clus_pkg::CAL_W-1:0]  hcal_in,
    input  logic [N_ETA*N_PHI-1:0]                  veto_in,
    input  logic [clus_pkg::TOW_W-1:0]              tower_thr,
    output clus_pkg::tower_t                        tow_q [N_ETA*N_PHI]
);
    import clus_pkg::*;
    localparam int N_T = N_ETA * N_PHI;

    for (genvar t = 0; t < N_T; t++) begin : g_tow
        logic [TOW_W-1:0] sum;
        tower_t           nxt;

        // Form the thresholded tower energy.
        always_comb begin
            sum      = {1'b0, ecal_in[t*CAL_W +: CAL_W]} + {1'b0, hcal_in[t*CAL_W +: CAL_W]};
            nxt.veto = veto_in[t];
            nxt.e    = (sum >= tower_thr) ? sum : '0;
        end

        // Stage 1 register for this tower.
        always_ff @(posedge clk) begin
            if (!rst_n) tow_q[t] <= '0;
            else        tow_q[t] <= nxt;
        end
    end
endmodule

// File: rtl/clus_window_sum.sv
// Module: clus_window_sum
// Sums a 2x2 window anchored at every grid position; the anchor is the
// lowest eta and phi corner. Towers beyond the upper grid edges count as
// zero. The vetoes of the in-grid towers are ORed. The results are
// registered as pipeline stage 2.
// Assumes: tower index t = eta*N_PHI + phi.
module clus_window_sum #(
    parameter int N_ETA = 8,
    parameter int N_PHI = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  clus_pkg::tower_t              tow   [N_ETA*N_PHI],
    output logic [clus_pkg::CLU_W-1:0]    sum_q [N_ETA*N_PHI],
    output logic [N_ETA*N_PHI-1:0]        veto_q
);
    import clus_pkg::*;

    for (genvar ie = 0; ie < N_ETA; ie++) begin : g_eta
        for (genvar ip = 0; ip < N_PHI; ip++) begin : g_phi
            localparam int I = ie*N_PHI + ip;
            tower_t t00, t10, t01, t11;

            // Select the four corners; absent corners become empty towers.
            assign t00 = tow[I];
            if (ie + 1 < N_ETA) begin : g_s
                assign t10 = tow[I + N_PHI];
            end else begin : g_s0
                assign t10 = '0;
            end
            if (ip + 1 < N_PHI) begin : g_e
                assign t01 = tow[I + 1];
            end else begin : g_e0
                assign t01 = '0;
            end
            if ((ie + 1 < N_ETA) && (ip + 1 < N_PHI)) begin : g_d
                assign t11 = tow[I + N_PHI + 1];
            end else begin : g_d0
                assign t11 = '0;
            end

            // Stage 2 register: window energy and combined veto.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sum_q[I]  <= '0;
                    veto_q[I] <= 1'b0;
                end else begin
                    sum_q[I]  <= CLU_W'(t00.e) + CLU_W'(t10.e) + CLU_W'(t01.e) + CLU_W'(t11.e);
                    veto_q[I] <= t00.veto | t10.veto | t01.veto | t11.veto;
                end
            end
        end
    end
endmodule

// File: rtl/clus_peak_filter.sv
// Module: clus_peak_filter
// Keeps a window only if it beats every overlapping in-grid window. It must
// be strictly greater than windows of lower raster index and greater or
// equal to those of higher index. It must also be non-zero and at least the
// pruning floor. Energy, veto and keep are registered as pipeline stage 3.
// Assumes: prune_thr is held steady while snapshots flow.
module clus_peak_filter #(
    parameter int N_ETA = 8,
    parameter int N_PHI = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [clus_pkg::CLU_W-1:0]       sum_in [N_ETA*N_PHI],
    input  logic [N_ETA*N_PHI-1:0]           veto_in,
    input  logic [clus_pkg::CLU_W-1:0]       prune_thr,
    output logic [N_ETA*N_PHI*clus_pkg::CLU_W-1:0] e_q,
    output logic [N_ETA*N_PHI-1:0]           keep_q,
    output logic [N_ETA*N_PHI-1:0]           veto_q
);
    import clus_pkg::*;

    for (genvar ie = 0; ie < N_ETA; ie++) begin : g_eta
        for (genvar ip = 0; ip < N_PHI; ip++) begin : g_phi
            localparam int I = ie*N_PHI + ip;
            logic [8:0] win;
            logic       keep_nxt;

            for (genvar de = 0; de < 3; de++) begin : g_de
                for (genvar dp = 0; dp < 3; dp++) begin : g_dp
                    localparam int NE = ie + de - 1;
                    localparam int NP = ip + dp - 1;
                    localparam int NI = NE*N_PHI + NP;
                    if (de == 1 && dp == 1) begin : g_self
                        assign win[de*3+dp] = 1'b1;
                    end else if (NE < 0 || NE >= N_ETA || NP < 0 || NP >= N_PHI) begin : g_out
                        assign win[de*3+dp] = 1'b1;
                    end else if (NI < I) begin : g_before
                        assign win[de*3+dp] = sum_in[I] > sum_in[NI];
                    end else begin : g_after
                        assign win[de*3+dp] = sum_in[I] >= sum_in[NI];
                    end
                end
            end

            // Combine the local-maximum vote with the prune and non-zero tests.
            always_comb begin
                keep_nxt = (&win) && (sum_in[I] >= prune_thr) && (sum_in[I] != '0);
            end

            // Stage 3 register for this position.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    e_q[I*CLU_W +: CLU_W] <= '0;
                    keep_q[I]             <= 1'b0;
                    veto_q[I]             <= 1'b0;
                end else begin
                    e_q[I*CLU_W +: CLU_W] <= sum_in[I];
                    keep_q[I]             <= keep_nxt;
                    veto_q[I]             <= veto_in[I];
                end
            end
        end
    end
endmodule

// File: rtl/clus_grid_top.sv
// Module: clus_grid_top
// Three-stage cluster finder: tower thresholding, overlapping 2x2 window
// sums, then the local-maximum and prune filter. A valid flag travels
// alongside the data.
// Assumes: both thresholds are static while snapshots are in flight.
module clus_grid_top #(
    parameter int N_ETA = 8,
    parameter int N_PHI = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [N_ETA*N_PHI*clus_pkg::CAL_W-1:0]   ecal_in,
    input  logic [N_ETA*N_PHI*clus_pkg::CAL_W-1:0]   hcal_in,
    input  logic [N_ETA*N_PHI-1:0]                   veto_in,
    input  logic [clus_pkg::TOW_W-1:0]               tower_thr,
    input  logic [clus_pkg::CLU_W-1:0]               prune_thr,
    output logic                                     out_valid,
    output logic [N_ETA*N_PHI*clus_pkg::CLU_W-1:0]   clus_e,
    output logic [N_ETA*N_PHI-1:0]                   clus_keep,
    output logic [N_ETA*N_PHI-1:0]                   clus_veto
);
    import clus_pkg::*;
    localparam int N_T   = N_ETA * N_PHI;
    localparam int DEPTH = 3;

    tower_t             tow   [N_T];
    logic [CLU_W-1:0]   wsum  [N_T];
    logic [N_T-1:0]     wveto;
    logic [DEPTH-1:0]   vld_q;

    // Carry the valid flag through the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[DEPTH-2:0], in_valid};
    end
    assign out_valid = vld_q[DEPTH-1];

    clus_tower_front #(.N_ETA(N_ETA), .N_PHI(N_PHI)) u_front (
        .clk(clk), .rst_n(rst_n), .ecal_in(ecal_in), .hcal_in(hcal_in),
        .veto_in(veto_in), .tower_thr(tower_thr), .tow_q(tow)
    );

    clus_window_sum #(.N_ETA(N_ETA), .N_PHI(N_PHI)) u_sum (
        .clk(clk), .rst_n(rst_n), .tow(tow), .sum_q(wsum), .veto_q(wveto)
    );

    clus_peak_filter #(.N_ETA(N_ETA), .N_PHI(N_PHI)) u_filt (
        .clk(clk), .rst_n(rst_n), .sum_in(wsum), .veto_in(wveto),
        .prune_thr(prune_thr), .e_q(clus_e), .keep_q(clus_keep), .veto_q(clus_veto)
    );
endmodule

// File: rtl/clus_grid_chk.sv
// Module: clus_grid_chk
// Property checker bound to clus_grid_top. It covers latency, pruning,
// non-zero keeps, exclusive keeps among overlapping windows, and reset.
// Assumes: tools accept bind of a module with matching port names.
module clus_grid_chk #(
    parameter int N_ETA = 8,
    parameter int N_PHI = 8
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   in_valid,
    input logic [clus_pkg::CLU_W-1:0]             prune_thr,
    input logic                                   out_valid,
    input logic [N_ETA*N_PHI*clus_pkg::CLU_W-1:0] clus_e,
    input logic [N_ETA*N_PHI-1:0]                 clus_keep
);
    import clus_pkg::*;
    logic [1:0] since_rst;

    // Count cycles out of reset, saturating, to bound $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7: out_valid mirrors in_valid three edges earlier.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R8: reset clears the valid flag and the keep map.
    a_r8_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && clus_keep == '0));

    for (genvar ie = 0; ie < N_ETA; ie++) begin : g_eta
        for (genvar ip = 0; ip < N_PHI; ip++) begin : g_phi
            localparam int I = ie*N_PHI + ip;
            // R5: a kept window reaches the pruning floor.
            a_r5_prune: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && clus_keep[I]) |-> (clus_e[I*CLU_W +: CLU_W] >= prune_thr));
            // R6: a kept window is never empty.
            a_r6_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
                clus_keep[I] |-> (clus_e[I*CLU_W +: CLU_W] != '0));
            // R4: overlapping windows are never both kept.
            if (ip + 1 < N_PHI) begin : g_e
                a_r4_excl_e: assert property (@(posedge clk) disable iff (!rst_n)
                    !(clus_keep[I] && clus_keep[I+1]));
            end
            if (ie + 1 < N_ETA) begin : g_s
                a_r4_excl_s: assert property (@(posedge clk) disable iff (!rst_n)
                    !(clus_keep[I] && clus_keep[I+N_PHI]));
            end
            if (ie + 1 < N_ETA && ip + 1 < N_PHI) begin : g_se
                a_r4_excl_se: assert property (@(posedge clk) disable iff (!rst_n)
                    !(clus_keep[I] && clus_keep[I+N_PHI+1]));
            end
            if (ie + 1 < N_ETA && ip > 0) begin : g_sw
                a_r4_excl_sw: assert property (@(posedge clk) disable iff (!rst_n)
                    !(clus_keep[I] && clus_keep[I+N_PHI-1]));
            end
        end
    end
endmodule

bind clus_grid_top clus_grid_chk #(.N_ETA(N_ETA), .N_PHI(N_PHI)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prune_thr(prune_thr),
    .out_valid(out_valid), .clus_e(clus_e), .clus_keep(clus_keep)
);

// File: tb/sim_clus_grid_top.sv
// Directed bench for clus_grid_top: one task per scenario, each checking
// its own results against a model built from the requirements.
module sim_clus_grid_top;
    localparam int NE = 8;
    localparam int NP = 8;
    localparam int NT = NE * NP;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NT*8-1:0] ecal_in = '0;
    logic [NT*8-1:0] hcal_in = '0;
    logic [NT-1:0]   veto_in = '0;
    logic [8:0]      tower_thr = '0;
    logic [10:0]     prune_thr = '0;
    logic            out_valid;
    logic [NT*11-1:0] clus_e;
    logic [NT-1:0]   clus_keep;
    logic [NT-1:0]   clus_veto;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    int ec [NT];
    int hc [NT];
    bit vt [NT];
    logic [NT*11-1:0] exp_e;
    logic [NT-1:0]    exp_k;
    logic [NT-1:0]    exp_v;

    always #10 clk = ~clk;

    clus_grid_top #(.N_ETA(NE), .N_PHI(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ecal_in(ecal_in),
        .hcal_in(hcal_in), .veto_in(veto_in), .tower_thr(tower_thr),
        .prune_thr(prune_thr), .out_valid(out_valid), .clus_e(clus_e),
        .clus_keep(clus_keep), .clus_veto(clus_veto)
    );

    task automatic check(input string req, input string what,
                         input logic [NT*11-1:0] act, input logic [NT*11-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic clear_grid();
        for (int t = 0; t < NT; t++) begin ec[t] = 0; hc[t] = 0; vt[t] = 0; end
    endtask

    // Reference built from R1..R6.
    task automatic model();
        int tw [NT];
        int cl [NT];
        for (int t = 0; t < NT; t++) begin
            int s = ec[t] + hc[t];
            tw[t] = (s >= tower_thr) ? s : 0;
        end
        for (int e = 0; e < NE; e++) for (int p = 0; p < NP; p++) begin
            int i = e*NP + p;
            int s = 0;
            bit v = 0;
            for (int a = 0; a < 2; a++) for (int b = 0; b < 2; b++)
                if (e+a < NE && p+b < NP) begin
                    s += tw[(e+a)*NP + p+b];
                    v |= vt[(e+a)*NP + p+b];
                end
            cl[i] = s;
            exp_v[i] = v;
            exp_e[i*11 +: 11] = 11'(s);
        end
        for (int e = 0; e < NE; e++) for (int p = 0; p < NP; p++) begin
            int i = e*NP + p;
            bit k = (cl[i] != 0) && (cl[i] >= prune_thr);
            for (int a = -1; a <= 1; a++) for (int b = -1; b <= 1; b++) begin
                int ne = e + a;
                int np = p + b;
                if ((a != 0 || b != 0) && ne >= 0 && ne < NE && np >= 0 && np < NP) begin
                    int j = ne*NP + np;
                    if (j < i) k &= (cl[i] > cl[j]);
                    else       k &= (cl[i] >= cl[j]);
                end
            end
            exp_k[i] = k;
        end
    endtask

    task automatic drive();
        for (int t = 0; t < NT; t++) begin
            ecal_in[t*8 +: 8] = 8'(ec[t]);
            hcal_in[t*8 +: 8] = 8'(hc[t]);
            veto_in[t]        = vt[t];
        end
        in_valid = 1'b1;
    endtask

    // Drive on a falling edge; results due three rising edges later.
    task automatic run_one(input string rq_e, input string rq_k, input string rq_v);
        model();
        @(negedge clk); drive();
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7", "out_valid", {{(NT*11-1){1'b0}}, out_valid}, {{(NT*11-1){1'b0}}, 1'b1});
        check(rq_e, "energy", clus_e, exp_e);
        check(rq_k, "keep", {{(NT*10){1'b0}}, clus_keep}, {{(NT*10){1'b0}}, exp_k});
        check(rq_v, "veto", {{(NT*10){1'b0}}, clus_veto}, {{(NT*10){1'b0}}, exp_v});
        @(negedge clk);
        check("R7", "valid_drop", {{(NT*11-1){1'b0}}, out_valid}, '0);
    endtask

    task automatic t_reset();   // R8
        check("R8", "valid", {{(NT*11-1){1'b0}}, out_valid}, '0);
        check("R8", "energy", clus_e, '0);
        check("R8", "keep_veto", {{(NT*9){1'b0}}, clus_keep, clus_veto}, '0);
    endtask

    task automatic t_single_tower();   // R1 R2 R4: one tower in four windows
        clear_grid(); tower_thr = 0; prune_thr = 1;
        ec[3*NP+4] = 100; hc[3*NP+4] = 50;
        run_one("R2", "R4", "R3");
        total++;
        if (clus_keep[2*NP+3] !== 1'b1 || clus_keep[3*NP+4] !== 1'b0) begin
            bad++;
            $display("FAIL R4 tie: actual=%b%b expected=10", clus_keep[2*NP+3], clus_keep[3*NP+4]);
        end
    endtask

    task automatic t_threshold();   // R1: below-floor towers vanish
        clear_grid(); tower_thr = 60; prune_thr = 0;
        ec[10] = 30; hc[10] = 29;
        ec[20] = 30; hc[20] = 30;
        ec[45] = 0;  hc[45] = 200;
        run_one("R1", "R4", "R3");
    endtask

    task automatic t_prune();   // R5: peaks below the floor dropped
        clear_grid(); tower_thr = 0; prune_thr = 300;
        ec[9] = 120; hc[9] = 100;
        ec[50] = 200; hc[50] = 180;
        run_one("R2", "R5", "R3");
    endtask

    task automatic t_veto();   // R3: veto OR independent of energy
        clear_grid(); tower_thr = 100; prune_thr = 0;
        vt[0] = 1; vt[27] = 1; vt[63] = 1;
        ec[27] = 10;
        run_one("R1", "R6", "R3");
    endtask

    task automatic t_edge_max();   // R2: edge windows and full-scale sums
        clear_grid(); tower_thr = 0; prune_thr = 0;
        for (int t = 0; t < NT; t++) begin ec[t] = 255; hc[t] = 255; end
        run_one("R2", "R4", "R3");
    endtask

    task automatic t_plateau();   // R4 R6: equal energies, zero prune floor
        clear_grid(); tower_thr = 0; prune_thr = 0;
        for (int t = 16; t < 32; t++) begin ec[t] = 40; end
        ec[60] = 7; hc[61] = 7;
        run_one("R4", "R6", "R3");
    endtask

    task automatic t_back_to_back();   // R7: two snapshots on adjacent cycles
        logic [NT*11-1:0] e_a;
        logic [NT-1:0]    k_a;
        clear_grid(); tower_thr = 0; prune_thr = 5;
        ec[5] = 90; hc[40] = 77;
        model(); e_a = exp_e; k_a = exp_k;
        @(negedge clk); drive();
        clear_grid(); ec[33] = 150; hc[34] = 20; vt[12] = 1;
        model();
        @(negedge clk); drive();
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R7", "first_energy", clus_e, e_a);
        check("R7", "first_keep", {{(NT*10){1'b0}}, clus_keep}, {{(NT*10){1'b0}}, k_a});
        @(negedge clk);
        check("R7", "second_valid", {{(NT*11-1){1'b0}}, out_valid}, {{(NT*11-1){1'b0}}, 1'b1});
        check("R7", "second_energy", clus_e, exp_e);
        check("R7", "second_keep", {{(NT*10){1'b0}}, clus_keep}, {{(NT*10){1'b0}}, exp_k});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single_tower();
        t_threshold();
        t_prune();
        t_veto();
        t_edge_max();
        t_plateau();
        t_back_to_back();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule